// File: doc/BRIEF.md
# DDR SDRAM Mode Register Command Unit

This block is the device-side logic that takes in and holds the operating settings of a double-data-rate SDRAM. It samples the four command strobes, the two bank-address bits and the address bus on every rising clock edge. It recognises a mode-register write and checks whether that write is legal. A legal write goes either to the base mode register or to the extended mode register. The base register's fields come out already decoded: read latency, burst ordering, burst length, test mode and a DLL-reset pulse.

The base register is stored in decoded form. Read latency is given as a count of half clock cycles, so the latencies of 1.5 and 2.5 cycles need no special case. After each accepted write the block refuses further writes for a short lockout. A write that is refused raises a one-cycle illegal-command flag. A write that holds a reserved field code sets a sticky error flag. The extended register is captured as a raw word, and its meaning is left to other logic.

Top module: `ddr_modereg_unit`

## Requirements
- R1: A mode-register write is recognised only when `cs_n`, `ras_n`, `cas_n` and `we_n` are all low at a rising edge. Any other strobe combination leaves every output unchanged and does not raise `cmd_illegal`.
- R2: `ba[0]`=0 targets the base register and `ba[0]`=1 targets the extended register, whose whole address word appears on `ext_mode` after the accepting edge. A write with `ba[1]`=1 is refused. An extended write leaves every base output unchanged.
- R3: A write is accepted only when `bank_active` is all zeros and `cke` was high at the previous rising edge. A write that fails either condition sets `cmd_illegal` high for the one cycle after that edge and changes no register.
- R4: After an accepted write, `busy` is high for the next 2 cycles. A write at either of those 2 edges is refused as in R3. A write at the third edge is accepted.
- R5: The base outputs and `ext_mode` change only on an accepted write to their own register.
- R6: `addr[6:4]` sets `cas_lat_half`: 010→4, 011→6, 100→8, 101→3, 110→5. The codes 000, 001 and 111 are reserved and give 0.
- R7: `addr[3]` sets `burst_ilv`: 0 selects sequential bursts and 1 selects interleaved bursts.
- R8: `addr[2:0]` sets `burst_len`: 001→2, 010→4, 011→8. Every other code is reserved and gives 0.
- R9: `addr[12:7]` is the operating mode. 000000 is normal. 000010 is normal with a DLL reset, and `dll_reset_pulse` is high for exactly the one cycle after the accepting edge. 000001 sets `test_mode` to 1 and it stays there. Every other value is reserved and makes `test_mode` 0.
- R10: `cfg_error` is set by a base write that holds any reserved code (R6, R8, R9). It is cleared by a base write with no reserved code. Extended writes and refused writes leave it unchanged.
- R11: A synchronous reset gives `cas_lat_half`=5, `burst_ilv`=0, `burst_len`=2, `test_mode`=0, `ext_mode`=0, and drops every flag and `busy`. It also clears the CKE history, so a write at the first edge after reset is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| cke | input | 1 | Clock enable, sampled for write legality |
| ba | input | 2 | Bank address; bit 0 selects the register, bit 1 must be 0 |
| addr | input | ADDR_W (13) | Address bus carrying the register value |
| bank_active | input | NUM_BANKS (4) | One bit per bank, high while that bank is open |
| cas_lat_half | output | 4 | Read latency in half clock cycles, 0 if reserved |
| burst_ilv | output | 1 | 1 for interleaved burst order |
| burst_len | output | 4 | Burst length in beats, 0 if reserved |
| test_mode | output | 1 | Test operating mode selected |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| ext_mode | output | ADDR_W (13) | Raw contents of the extended register |
| cmd_illegal | output | 1 | One-cycle flag for a refused write |
| cfg_error | output | 1 | Sticky flag for a reserved field code |
| busy | output | 1 | Post-write lockout in progress |

## Verification
On every cycle, the assertions check the following. An accepted write always had CKE high the cycle before and is always followed by `busy` with no second acceptance. A write against an open bank always yields `cmd_illegal`. The decoded base fields and `ext_mode` stay stable unless their own register was written. The DLL pulse never lasts two cycles, and the latency output is a legal value whenever no error is flagged. Several behaviours can only be shown by the bench's directed scenarios: the exact code-to-value mapping of each field, the sticky error clearing only on a clean base write, the refusal at the first edge after reset, and the exact length of the lockout. The bench then compares every output against a behavioural model on every cycle of a long randomised run.

// File: rtl/modereg_pkg.sv
package modereg_pkg;
  // bit positions the field decoder relies on
  localparam int CL_LSB  = 4;
  localparam int BT_BIT  = 3;
  localparam int BL_LSB  = 0;
  localparam int OPM_LSB = 7;

  typedef struct packed {
    logic [3:0] cl_half;
    logic       ilv;
    logic [3:0] blen;
    logic       dll_rst;
    logic       test;
    logic       bad;
  } mode_fields_t;
endpackage

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
  import modereg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] word,
  output mode_fields_t      fld
);
  localparam int OPM_W = ADDR_W - OPM_LSB;

  logic [OPM_W-1:0] opm;
  logic             cl_bad;
  logic             bl_bad;
  logic             opm_bad;

  always_comb begin
    opm    = word[ADDR_W-1:OPM_LSB];
    cl_bad = 1'b0;
    bl_bad = 1'b0;
    unique case (word[CL_LSB +: 3])
      3'b010:  fld.cl_half = 4'd4;
      3'b011:  fld.cl_half = 4'd6;
      3'b100:  fld.cl_half = 4'd8;
      3'b101:  fld.cl_half = 4'd3;
      3'b110:  fld.cl_half = 4'd5;
      default: begin fld.cl_half = 4'd0; cl_bad = 1'b1; end
    endcase
    unique case (word[BL_LSB +: 3])
      3'b001:  fld.blen = 4'd2;
      3'b010:  fld.blen = 4'd4;
      3'b011:  fld.blen = 4'd8;
      default: begin fld.blen = 4'd0; bl_bad = 1'b1; end
    endcase
    fld.ilv     = word[BT_BIT];
    fld.dll_rst = (opm == OPM_W'(2));
    fld.test    = (opm == OPM_W'(1));
    opm_bad     = !((opm == '0) || fld.dll_rst || fld.test);
    fld.bad     = cl_bad | bl_bad | opm_bad;
  end
endmodule

// File: rtl/mrs_cmd_gate.sv
module mrs_cmd_gate #(
  parameter int NUM_BANKS = 4,
  parameter int LOCK_CYC  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke,
  input  logic [1:0]           ba,
  input  logic [NUM_BANKS-1:0] bank_active,
  output logic                 acc_base,
  output logic                 acc_ext,
  output logic                 reject,
  output logic                 busy
);
  localparam int LOCK_W = $clog2(LOCK_CYC + 1);

  logic              cke_q;
  logic [LOCK_W-1:0] lock_cnt;
  logic              mrs_hit;
  logic              legal;
  logic              acc;

  always_comb begin
    mrs_hit  = !rst && !cs_n && !ras_n && !cas_n && !we_n;
    legal    = cke_q && !(|bank_active) && (lock_cnt == '0) && !ba[1];
    acc      = mrs_hit && legal;
    acc_base = acc && !ba[0];
    acc_ext  = acc && ba[0];
    reject   = mrs_hit && !legal;
    busy     = (lock_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q    <= 1'b0;
      lock_cnt <= '0;
    end else begin
      cke_q <= cke;
      if (acc)
        lock_cnt <= LOCK_W'(LOCK_CYC);
      else if (lock_cnt != '0)
        lock_cnt <= lock_cnt - 1'b1;
    end
  end

  AST_LOCK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $past(acc) |-> (busy && !acc)); // R4
endmodule

// File: rtl/ddr_modereg_unit.sv
module ddr_modereg_unit
  import modereg_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int NUM_BANKS = 4,
  parameter int LOCK_CYC  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke,
  input  logic [1:0]           ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bank_active,
  output logic [3:0]           cas_lat_half,
  output logic                 burst_ilv,
  output logic [3:0]           burst_len,
  output logic                 test_mode,
  output logic                 dll_reset_pulse,
  output logic [ADDR_W-1:0]    ext_mode,
  output logic                 cmd_illegal,
  output logic                 cfg_error,
  output logic                 busy
);
  logic         acc_base;
  logic         acc_ext;
  logic         reject;
  mode_fields_t fld;

  mrs_cmd_gate #(
    .NUM_BANKS(NUM_BANKS),
    .LOCK_CYC (LOCK_CYC)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .cke        (cke),
    .ba         (ba),
    .bank_active(bank_active),
    .acc_base   (acc_base),
    .acc_ext    (acc_ext),
    .reject     (reject),
    .busy       (busy)
  );

  mrs_field_decode #(
    .ADDR_W(ADDR_W)
  ) u_dec (
    .word(addr),
    .fld (fld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_lat_half    <= 4'd5;
      burst_ilv       <= 1'b0;
      burst_len       <= 4'd2;
      test_mode       <= 1'b0;
      dll_reset_pulse <= 1'b0;
      ext_mode        <= '0;
      cmd_illegal     <= 1'b0;
      cfg_error       <= 1'b0;
    end else begin
      cmd_illegal     <= reject;
      dll_reset_pulse <= 1'b0;
      if (acc_base) begin
        cas_lat_half    <= fld.cl_half;
        burst_ilv       <= fld.ilv;
        burst_len       <= fld.blen;
        test_mode       <= fld.test;
        dll_reset_pulse <= fld.dll_rst;
        cfg_error       <= fld.bad;
      end
      if (acc_ext)
        ext_mode <= addr;
    end
  end

  // port-level view of a write strobe pattern, for the checks below
  logic mrs_seen;
  assign mrs_seen = !cs_n && !ras_n && !cas_n && !we_n;

  AST_CKE_HISTORY: assert property (@(posedge clk) disable iff (rst)
    (acc_base || acc_ext) |-> $past(cke)); // R3
  AST_OPEN_BANK_REFUSED: assert property (@(posedge clk) disable iff (rst)
    $past(mrs_seen && (|bank_active) && !rst) |-> cmd_illegal); // R3
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_base) |-> ($stable(cas_lat_half) && $stable(burst_len) && $stable(burst_ilv) && $stable(test_mode))); // R5
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_ext) |-> $stable(ext_mode)); // R2
  AST_DLL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dll_reset_pulse |=> !dll_reset_pulse); // R9
  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    !cfg_error |-> (cas_lat_half inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd8})); // R6
endmodule

// File: tb/test_ddr_modereg_unit.sv
`timescale 1ns/1ps
module test_ddr_modereg_unit;
  localparam int AW = 13;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    strb = 4'b1111;   // {cs_n, ras_n, cas_n, we_n}
  logic          cke = 1'b1;
  logic [1:0]    ba = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bank_active = '0;

  logic [3:0]    cas_lat_half;
  logic          burst_ilv;
  logic [3:0]    burst_len;
  logic          test_mode;
  logic          dll_reset_pulse;
  logic [AW-1:0] ext_mode;
  logic          cmd_illegal;
  logic          cfg_error;
  logic          busy;

  always #4 clk = ~clk;

  ddr_modereg_unit #(.ADDR_W(AW), .NUM_BANKS(NB), .LOCK_CYC(2)) i_ddr_modereg_unit (
    .clk(clk), .rst(rst),
    .cs_n(strb[3]), .ras_n(strb[2]), .cas_n(strb[1]), .we_n(strb[0]),
    .cke(cke), .ba(ba), .addr(addr), .bank_active(bank_active),
    .cas_lat_half(cas_lat_half), .burst_ilv(burst_ilv), .burst_len(burst_len),
    .test_mode(test_mode), .dll_reset_pulse(dll_reset_pulse), .ext_mode(ext_mode),
    .cmd_illegal(cmd_illegal), .cfg_error(cfg_error), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cl = 5, m_bl = 2, m_lock = 0;
  bit m_ilv = 0, m_test = 0, m_dll = 0, m_ill = 0, m_err = 0, m_cke_q = 0;
  int m_ext = 0;

  always @(posedge clk) begin
    bit hit, ok, bad;
    int op;
    cmp_en <= 1'b1;
    if (rst) begin
      m_cl = 5; m_bl = 2; m_ilv = 0; m_test = 0; m_dll = 0; m_ill = 0;
      m_err = 0; m_ext = 0; m_lock = 0; m_cke_q = 0;
    end else begin
      hit = (strb == 4'b0000);
      ok  = m_cke_q && (bank_active == 0) && (m_lock == 0) && !ba[1];
      m_dll = 0;
      m_ill = hit && !ok;
      if (hit && ok) begin
        if (ba[0]) m_ext = int'(addr);
        else begin
          bad = 0;
          case (int'(addr[6:4]))
            2: m_cl = 4; 3: m_cl = 6; 4: m_cl = 8; 5: m_cl = 3; 6: m_cl = 5;
            default: begin m_cl = 0; bad = 1; end
          endcase
          case (int'(addr[2:0]))
            1: m_bl = 2; 2: m_bl = 4; 3: m_bl = 8;
            default: begin m_bl = 0; bad = 1; end
          endcase
          m_ilv = addr[3];
          op = int'(addr[12:7]);
          m_test = (op == 1);
          m_dll  = (op == 2);
          if (op > 2) bad = 1;
          m_err = bad;
        end
        m_lock = 2;
      end else if (m_lock > 0) m_lock--;
      m_cke_q = cke;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R6 cas_lat_half model", int'(cas_lat_half), m_cl);
      chk("R8 burst_len model", int'(burst_len), m_bl);
      chk("R7 burst_ilv model", int'(burst_ilv), int'(m_ilv));
      chk("R9 test_mode model", int'(test_mode), int'(m_test));
      chk("R9 dll_reset_pulse model", int'(dll_reset_pulse), int'(m_dll));
      chk("R2 ext_mode model", int'(ext_mode), m_ext);
      chk("R3 cmd_illegal model", int'(cmd_illegal), int'(m_ill));
      chk("R10 cfg_error model", int'(cfg_error), int'(m_err));
      chk("R4 busy model", int'(busy), int'(m_lock != 0));
    end
  end

  // one cycle: outputs now reflect the previous edge; then drive the next command
  task automatic cyc(input logic [3:0] s, input logic [1:0] b, input logic [AW-1:0] a);
    @(negedge clk); #1;
    strb = s; ba = b; addr = a;
  endtask

  task automatic wr(input logic [1:0] b, input logic [AW-1:0] a);
    cyc(4'b1111, 2'b00, '0);
    cyc(4'b0000, b, a);
    cyc(4'b1111, 2'b00, '0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1;
    chk("R11 reset cas_lat_half", int'(cas_lat_half), 5);
    chk("R11 reset burst_len", int'(burst_len), 2);
    chk("R11 reset burst_ilv", int'(burst_ilv), 0);
    chk("R11 reset ext_mode", int'(ext_mode), 0);
    // release reset and write at once: CKE history is cleared
    rst = 1'b0; strb = 4'b0000; ba = 2'b00; addr = 13'h032;
    cyc(4'b1111, 2'b00, '0);
    chk("R11 first write after reset refused", int'(cmd_illegal), 1);
    chk("R11 first write after reset no effect", int'(cas_lat_half), 5);

    wr(2'b00, 13'h032);
    chk("R6 CL code 011", int'(cas_lat_half), 6);
    chk("R8 BL code 010", int'(burst_len), 4);
    chk("R4 busy after accept", int'(busy), 1);

    // back-to-back writes: two refused during lockout, third accepted
    cyc(4'b1111, 2'b00, '0);
    cyc(4'b0000, 2'b00, 13'h022);
    cyc(4'b0000, 2'b00, 13'h042);
    chk("R4 first write accepted", int'(cas_lat_half), 4);
    cyc(4'b0000, 2'b00, 13'h032);
    chk("R4 refused in lockout cycle 1", int'(cmd_illegal), 1);
    cyc(4'b0000, 2'b00, 13'h05B);
    chk("R4 refused in lockout cycle 2", int'(cmd_illegal), 1);
    chk("R4 lockout leaves register", int'(cas_lat_half), 4);
    cyc(4'b1111, 2'b00, '0);
    chk("R4 write after lockout accepted", int'(cmd_illegal), 0);
    chk("R6 CL code 101", int'(cas_lat_half), 3);
    chk("R7 interleave", int'(burst_ilv), 1);
    chk("R8 BL code 011", int'(burst_len), 8);

    // non-write strobes are ignored
    cyc(4'b1111, 2'b00, '0);
    cyc(4'b0011, 2'b00, 13'h022);
    cyc(4'b0100, 2'b00, 13'h022);
    cyc(4'b1111, 2'b00, '0);
    chk("R1 other strobes ignored", int'(cas_lat_half), 3);
    chk("R1 other strobes no flag", int'(cmd_illegal), 0);

    wr(2'b01, 13'h1AB);
    chk("R2 extended capture", int'(ext_mode), 32'h1AB);
    chk("R2 extended leaves base", int'(cas_lat_half), 3);

    wr(2'b10, 13'h022);
    chk("R2 ba1 set refused", int'(cmd_illegal), 1);
    chk("R2 ba1 set no effect", int'(cas_lat_half), 3);

    bank_active = 4'b0100;
    wr(2'b00, 13'h022);
    chk("R3 open bank refused", int'(cmd_illegal), 1);
    chk("R3 open bank no effect", int'(cas_lat_half), 3);
    bank_active = '0;

    cyc(4'b1111, 2'b00, '0); cke = 1'b0;
    cyc(4'b0000, 2'b00, 13'h022); cke = 1'b1;
    cyc(4'b1111, 2'b00, '0);
    chk("R3 cke low before refused", int'(cmd_illegal), 1);
    chk("R3 cke low before no effect", int'(cas_lat_half), 3);

    wr(2'b00, 13'h002);
    chk("R6 reserved CL gives 0", int'(cas_lat_half), 0);
    chk("R10 reserved CL sets error", int'(cfg_error), 1);
    wr(2'b01, 13'h005);
    chk("R10 ext write keeps error", int'(cfg_error), 1);
    wr(2'b00, 13'h024);
    chk("R8 reserved BL gives 0", int'(burst_len), 0);
    chk("R10 error still set", int'(cfg_error), 1);

    wr(2'b00, 13'h162);
    chk("R9 DLL pulse", int'(dll_reset_pulse), 1);
    chk("R10 clean write clears error", int'(cfg_error), 0);
    cyc(4'b1111, 2'b00, '0);
    chk("R9 DLL pulse one cycle", int'(dll_reset_pulse), 0);

    wr(2'b00, 13'h0E2);
    chk("R9 test mode set", int'(test_mode), 1);
    cyc(4'b1111, 2'b00, '0);
    chk("R9 test mode held", int'(test_mode), 1);

    wr(2'b00, 13'h262);
    chk("R9 reserved op clears test", int'(test_mode), 0);
    chk("R10 reserved op sets error", int'(cfg_error), 1);

    wr(2'b00, 13'h061);
    chk("R6 CL code 110", int'(cas_lat_half), 5);
    chk("R10 cleared again", int'(cfg_error), 0);

    // randomised run, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] s;
      logic [AW-1:0] a;
      s = ($urandom % 3 == 0) ? 4'b0000 : 4'($urandom);
      a = AW'($urandom);
      case ($urandom % 4)
        0: a[12:7] = 6'd0;
        1: a[12:7] = 6'd1;
        2: a[12:7] = 6'd2;
        default: ;
      endcase
      cyc(s, {($urandom % 8 == 0), 1'($urandom)}, a);
      bank_active = ($urandom % 6 == 0) ? NB'($urandom) : '0;
      cke = ($urandom % 10 != 0);
    end
    cyc(4'b1111, 2'b00, '0);
    cyc(4'b1111, 2'b00, '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule